// File: doc/BRIEF.md
# Shift-Based Route Computation Unit

This unit decides, at every router hop of a 2D mesh, which output a flit leaves on: east, west, north, south or the local ejection port. It also rewrites the header route fields that the next router will see. The remaining distance in each dimension is kept as a one-hot vector, where bit 0 means no hops are left. Each hop moves the bit one place down by a shift, so the unit needs no subtractor and no coordinate comparator. A sign bit per dimension selects the direction of travel.

Three routing policies can be picked per flit. Two are dimension ordered: X first then Y, or Y first then X. The third is source routing, where the header holds a list of 3-bit port codes. The lowest entry is used at this hop, and the list is then shifted down by one entry, with an eject code filled in at the top. The logic is combinational. An output register stage can be selected by parameter for pipelined routers and is enabled by default.

Top module: `route_compute`

## Requirements
- R1: In mode 0 (XY), a flit whose X field is not at zero hops leaves on the X port. Once X is at zero, a non-zero Y field sends it on the Y port.
- R2: In mode 1 (YX), the Y field is served first and the X field second, using the same rule as R1.
- R3: Only the dimension being travelled is updated, by shifting its one-hot field right by one place. The other field is passed on unchanged.
- R4: Port codes are 0 local, 1 east, 2 west, 3 north and 4 south. An X sign of 0 selects east and 1 selects west. A Y sign of 0 selects north and 1 selects south. Both sign bits are passed to the next hop unchanged.
- R5: In a dimension-ordered mode, when both fields are at zero hops (bit 0 set), the output is local and both fields are passed on unchanged.
- R6: A hop field that is all zeros is treated as zero hops remaining.
- R7: In mode 2 (source), the output port is the code in bits [2:0] of the list. The next list is the input list shifted right by 3 bits, with zeros filled in at the top.
- R8: A source code of 5, 6 or 7 sends the flit to the local port.
- R9: Source mode passes both hop fields through unchanged. Both dimension-ordered modes pass the source list through unchanged.
- R10: Mode code 3 behaves exactly like XY.
- R11: With the register stage enabled, every output appears one clock after its inputs. out_valid follows in_valid one cycle later, and reset drives out_valid and out_port to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header fields are valid this cycle |
| mode | input | 2 | 0 XY, 1 YX, 2 source, 3 same as XY |
| x_neg | input | 1 | X direction, 1 = west |
| x_hot | input | X_HOPS+1 | One-hot remaining X hops, bit 0 = none |
| y_neg | input | 1 | Y direction, 1 = south |
| y_hot | input | Y_HOPS+1 | One-hot remaining Y hops, bit 0 = none |
| src_list | input | 3*SRC_DEPTH | Source route codes, current entry in bits [2:0] |
| out_valid | output | 1 | Result valid |
| out_port | output | 3 | Selected output port code |
| nxt_x_neg | output | 1 | X sign for the next hop |
| nxt_x_hot | output | X_HOPS+1 | X field for the next hop |
| nxt_y_neg | output | 1 | Y sign for the next hop |
| nxt_y_hot | output | Y_HOPS+1 | Y field for the next hop |
| nxt_src_list | output | 3*SRC_DEPTH | Source list for the next hop |

## Verification
Dimension-ordered headers are applied with both fields pending, only X pending, only Y pending and neither pending, in both XY and YX order. This separates the two orders and also checks the ejection rule. Sign bits are flipped across these cases so that east and west, and north and south, are each distinguished. The largest hop value and an all-zero field exercise the two ends of the shift. Source lists are walked over consecutive hops, with codes out of range and an empty list, to confirm that the entries are consumed and that the hop fields are left untouched in that mode.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_EAST  = 3'd1,
        P_WEST  = 3'd2,
        P_NORTH = 3'd3,
        P_SOUTH = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        M_XY  = 2'd0,
        M_YX  = 2'd1,
        M_SRC = 2'd2,
        M_RSV = 2'd3
    } mode_e;

    localparam int CODE_W = 3;

    // Map a raw source-route code to a port; out-of-range codes eject.
    function automatic port_e code_to_port(input logic [CODE_W-1:0] c);
        if (c <= 3'd4) return port_e'(c);
        else           return P_LOCAL;
    endfunction

    // A field with bit 0 set or no bit at all has no hops left.
    function automatic logic hops_done(input logic lsb, input logic any_set);
        return lsb | ~any_set;
    endfunction

endpackage

// File: rtl/rc_dor_step.sv
module rc_dor_step
    import rc_pkg::*;
#(
    parameter int XW = 5,
    parameter int YW = 5
) (
    input  logic          yx_first,
    input  logic          x_neg,
    input  logic [XW-1:0] x_hot,
    input  logic          y_neg,
    input  logic [YW-1:0] y_hot,
    output port_e         port,
    output logic [XW-1:0] nx_hot,
    output logic [YW-1:0] ny_hot
);
    logic x_zero, y_zero, x_go, y_go;

    always_comb begin
        x_zero = hops_done(x_hot[0], |x_hot);
        y_zero = hops_done(y_hot[0], |y_hot);
        x_go   = !x_zero && (!yx_first || y_zero);
        y_go   = !y_zero && ( yx_first || x_zero);

        port   = P_LOCAL;
        nx_hot = x_hot;
        ny_hot = y_hot;
        if (x_go) begin
            port   = x_neg ? P_WEST : P_EAST;
            nx_hot = x_hot >> 1;
        end else if (y_go) begin
            port   = y_neg ? P_SOUTH : P_NORTH;
            ny_hot = y_hot >> 1;
        end
    end
endmodule

// File: rtl/rc_src_step.sv
module rc_src_step
    import rc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LW   = DEPTH * CODE_W
) (
    input  logic [LW-1:0] list_in,
    output port_e         port,
    output logic [LW-1:0] list_out
);
    always_comb begin
        port     = code_to_port(list_in[CODE_W-1:0]);
        list_out = list_in >> CODE_W;
    end
endmodule

// File: rtl/rc_out_stage.sv
module rc_out_stage #(
    parameter int W          = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_comb
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/route_compute.sv
module route_compute
    import rc_pkg::*;
#(
    parameter int X_HOPS     = 4,
    parameter int Y_HOPS     = 4,
    parameter int SRC_DEPTH  = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [1:0]                 mode,
    input  logic                       x_neg,
    input  logic [X_HOPS:0]            x_hot,
    input  logic                       y_neg,
    input  logic [Y_HOPS:0]            y_hot,
    input  logic [3*SRC_DEPTH-1:0]     src_list,
    output logic                       out_valid,
    output logic [2:0]                 out_port,
    output logic                       nxt_x_neg,
    output logic [X_HOPS:0]            nxt_x_hot,
    output logic                       nxt_y_neg,
    output logic [Y_HOPS:0]            nxt_y_hot,
    output logic [3*SRC_DEPTH-1:0]     nxt_src_list
);
    localparam int XW = X_HOPS + 1;
    localparam int YW = Y_HOPS + 1;
    localparam int LW = CODE_W * SRC_DEPTH;
    localparam int OW = 1 + CODE_W + 1 + XW + 1 + YW + LW;

    port_e          dor_port, src_port, sel_port;
    logic [XW-1:0]  dor_x, sel_x;
    logic [YW-1:0]  dor_y, sel_y;
    logic [LW-1:0]  src_next, sel_list;
    logic [OW-1:0]  stage_d, stage_q;

    rc_dor_step #(.XW(XW), .YW(YW)) dor_i (
        .yx_first (mode_e'(mode) == M_YX),
        .x_neg    (x_neg),
        .x_hot    (x_hot),
        .y_neg    (y_neg),
        .y_hot    (y_hot),
        .port     (dor_port),
        .nx_hot   (dor_x),
        .ny_hot   (dor_y)
    );

    rc_src_step #(.DEPTH(SRC_DEPTH)) src_i (
        .list_in  (src_list),
        .port     (src_port),
        .list_out (src_next)
    );

    always_comb begin
        if (mode_e'(mode) == M_SRC) begin
            sel_port = src_port;
            sel_x    = x_hot;
            sel_y    = y_hot;
            sel_list = src_next;
        end else begin
            sel_port = dor_port;
            sel_x    = dor_x;
            sel_y    = dor_y;
            sel_list = src_list;
        end
    end

    assign stage_d = {in_valid, sel_port, x_neg, sel_x, y_neg, sel_y, sel_list};

    rc_out_stage #(.W(OW), .REGISTERED(REGISTERED)) out_i (
        .clk (clk),
        .rst (rst),
        .d   (stage_d),
        .q   (stage_q)
    );

    assign {out_valid, out_port, nxt_x_neg, nxt_x_hot,
            nxt_y_neg, nxt_y_hot, nxt_src_list} = stage_q;
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
    parameter int XW         = 5,
    parameter int YW         = 5,
    parameter int LW         = 12,
    parameter bit REGISTERED = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    mode,
    input logic [XW-1:0] x_hot,
    input logic [YW-1:0] y_hot,
    input logic [LW-1:0] src_list,
    input logic          out_valid,
    input logic [2:0]    out_port,
    input logic [XW-1:0] nxt_x_hot,
    input logic [YW-1:0] nxt_y_hot
);
    generate
        if (REGISTERED) begin : g_chk
            // R11: valid is delayed by exactly one stage
            a_r11_valid_delay: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> out_valid == $past(in_valid));

            // R1: XY with X pending goes east or west
            a_r1_x_first: assert property (@(posedge clk) disable iff (rst)
                in_valid && mode == 2'd0 && !x_hot[0] && |x_hot
                |=> out_port == 3'd1 || out_port == 3'd2);

            // R2: YX with Y pending goes north or south
            a_r2_y_first: assert property (@(posedge clk) disable iff (rst)
                in_valid && mode == 2'd1 && !y_hot[0] && |y_hot
                |=> out_port == 3'd3 || out_port == 3'd4);

            // R5: both dimensions done ejects with fields intact
            a_r5_eject: assert property (@(posedge clk) disable iff (rst)
                in_valid && mode != 2'd2 && (x_hot[0] || ~|x_hot) && (y_hot[0] || ~|y_hot)
                |=> out_port == 3'd0 && nxt_x_hot == $past(x_hot) && nxt_y_hot == $past(y_hot));

            // R3: a one-hot X field stays one-hot
            a_r3_onehot_kept: assert property (@(posedge clk) disable iff (rst)
                in_valid && mode != 2'd2 && $onehot(x_hot) |=> $onehot(nxt_x_hot));

            // R9: source mode leaves hop fields alone
            a_r9_src_keeps_hops: assert property (@(posedge clk) disable iff (rst)
                in_valid && mode == 2'd2
                |=> nxt_x_hot == $past(x_hot) && nxt_y_hot == $past(y_hot));

            // R8: out-of-range source code ejects
            a_r8_bad_code: assert property (@(posedge clk) disable iff (rst)
                in_valid && mode == 2'd2 && src_list[2:0] > 3'd4 |=> out_port == 3'd0);
        end
    endgenerate
endmodule

bind route_compute rc_checker #(
    .XW(X_HOPS + 1), .YW(Y_HOPS + 1), .LW(3 * SRC_DEPTH), .REGISTERED(REGISTERED)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .x_hot(x_hot), .y_hot(y_hot), .src_list(src_list),
    .out_valid(out_valid), .out_port(out_port),
    .nxt_x_hot(nxt_x_hot), .nxt_y_hot(nxt_y_hot)
);

// File: tb/route_compute_tb_top.sv
module route_compute_tb_top;

    typedef struct packed {
        logic [1:0]  mode;
        logic        xn;
        logic [4:0]  xh;
        logic        yn;
        logic [4:0]  yh;
        logic [11:0] src;
        logic [2:0]  ep;
        logic [4:0]  ex;
        logic [4:0]  ey;
        logic [11:0] es;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0,1'b0,5'b00100,1'b0,5'b00010,12'hABC, 3'd1,5'b00010,5'b00010,12'hABC, 4'd1},  // R1 R3
        '{2'd0,1'b1,5'b00010,1'b0,5'b01000,12'hABC, 3'd2,5'b00001,5'b01000,12'hABC, 4'd4},  // R4 west
        '{2'd0,1'b0,5'b00001,1'b0,5'b00100,12'hABC, 3'd3,5'b00001,5'b00010,12'hABC, 4'd1},  // R1 then Y
        '{2'd0,1'b0,5'b00001,1'b1,5'b00010,12'hABC, 3'd4,5'b00001,5'b00001,12'hABC, 4'd4},  // R4 south
        '{2'd0,1'b1,5'b00001,1'b1,5'b00001,12'hABC, 3'd0,5'b00001,5'b00001,12'hABC, 4'd5},  // R5
        '{2'd1,1'b0,5'b00100,1'b0,5'b00010,12'hABC, 3'd3,5'b00100,5'b00001,12'hABC, 4'd2},  // R2
        '{2'd1,1'b1,5'b00100,1'b0,5'b00001,12'hABC, 3'd2,5'b00010,5'b00001,12'hABC, 4'd2},  // R2 then X
        '{2'd1,1'b0,5'b00001,1'b0,5'b00001,12'h123, 3'd0,5'b00001,5'b00001,12'h123, 4'd5},  // R5 YX
        '{2'd2,1'b0,5'b00100,1'b0,5'b00010,12'h899, 3'd1,5'b00100,5'b00010,12'h113, 4'd7},  // R7
        '{2'd2,1'b1,5'b01000,1'b1,5'b10000,12'h113, 3'd3,5'b01000,5'b10000,12'h022, 4'd9},  // R9
        '{2'd2,1'b0,5'b00001,1'b0,5'b00001,12'h007, 3'd0,5'b00001,5'b00001,12'h000, 4'd8},  // R8 code 7
        '{2'd2,1'b0,5'b00010,1'b0,5'b00010,12'h000, 3'd0,5'b00010,5'b00010,12'h000, 4'd7},  // R7 empty
        '{2'd0,1'b0,5'b00000,1'b1,5'b00010,12'hABC, 3'd4,5'b00000,5'b00001,12'hABC, 4'd6},  // R6
        '{2'd3,1'b0,5'b01000,1'b0,5'b00010,12'hABC, 3'd1,5'b00100,5'b00010,12'hABC, 4'd10}, // R10
        '{2'd0,1'b0,5'b10000,1'b0,5'b10000,12'hABC, 3'd1,5'b01000,5'b10000,12'hABC, 4'd3},  // R3 max
        '{2'd1,1'b1,5'b00000,1'b0,5'b00000,12'hABC, 3'd0,5'b00000,5'b00000,12'hABC, 4'd6},  // R6 both
        '{2'd2,1'b0,5'b00001,1'b0,5'b00001,12'h015, 3'd0,5'b00001,5'b00001,12'h002, 4'd8}   // R8 code 5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = '0;
    logic        x_neg = 1'b0, y_neg = 1'b0;
    logic [4:0]  x_hot = '0, y_hot = '0;
    logic [11:0] src_list = '0;
    logic        out_valid, nxt_x_neg, nxt_y_neg;
    logic [2:0]  out_port;
    logic [4:0]  nxt_x_hot, nxt_y_hot;
    logic [11:0] nxt_src_list;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    route_compute dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
        .x_neg(x_neg), .x_hot(x_hot), .y_neg(y_neg), .y_hot(y_hot),
        .src_list(src_list), .out_valid(out_valid), .out_port(out_port),
        .nxt_x_neg(nxt_x_neg), .nxt_x_hot(nxt_x_hot), .nxt_y_neg(nxt_y_neg),
        .nxt_y_hot(nxt_y_hot), .nxt_src_list(nxt_src_list)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1;
        mode     = v.mode;
        x_neg    = v.xn;
        x_hot    = v.xh;
        y_neg    = v.yn;
        y_hot    = v.yh;
        src_list = v.src;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        logic [63:0] act, exp;
        act = {out_valid, out_port, nxt_x_neg, nxt_x_hot, nxt_y_neg, nxt_y_hot, nxt_src_list};
        exp = {1'b1, v.ep, v.xn, v.ex, v.yn, v.ey, v.es};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d vector %0d actual=%h expected=%h", v.req, idx, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset out_valid", 64'(out_valid), 64'd0);
        check("R11 reset out_port", 64'(out_port), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i], i);
        end

        // R11: idle input gives invalid output
        in_valid = 1'b0;
        @(negedge clk);
        check("R11 idle", 64'(out_valid), 64'd0);

        // R11: back-to-back flits, one result per cycle
        drive(VECS[0]);
        @(negedge clk);
        drive(VECS[5]);
        check_vec(VECS[0], 0);
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(VECS[5], 5);

        // R7: multi-hop walk of a source list through consecutive hops
        drive(VECS[8]);
        @(negedge clk);
        src_list = nxt_src_list;
        check("R7 hop1 port", 64'(out_port), 64'd1);
        @(negedge clk);
        src_list = nxt_src_list;
        check("R7 hop2 port", 64'(out_port), 64'd3);
        @(negedge clk);
        src_list = nxt_src_list;
        check("R7 hop3 port", 64'(out_port), 64'd2);
        @(negedge clk);
        src_list = nxt_src_list;
        check("R7 hop4 port", 64'(out_port), 64'd4);
        @(negedge clk);
        check("R7 hop5 port", 64'(out_port), 64'd0);
        check("R7 hop5 list", 64'(nxt_src_list), 64'd0);

        // R11: reset in mid-run clears valid
        drive(VECS[0]);
        rst = 1'b1;
        @(negedge clk);
        check("R11 mid reset valid", 64'(out_valid), 64'd0);
        check("R11 mid reset port", 64'(out_port), 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule